// File: doc/BRIEF.md
# Iterative Step Integer Divider

An unsigned divider for wide operands that a sequencer drives one operation at a time. A start operation loads the upper part of a dividend as the running remainder. It latches the divisor and makes a first align-and-subtract pass. Each step operation then feeds bits from a low-dividend register into the remainder, up to a given count, and makes one more align-and-subtract pass. It hands back how many low bits are still to be consumed.

An align-and-subtract pass does not use a fixed one-bit restoring loop. It lines the divisor's top set bit up with the remainder's top set bit, backs off one place if that overshoots, and subtracts. This can retire several quotient bit positions in one pass.

Two read operations return the held quotient and remainder. Every result, including the step count, is written into the low lanes of a caller-supplied destination word at a selectable width. The upper lanes of that word are left as they were. Each accepted operation takes effect on its clock edge, and its result is presented one cycle after it is issued.

Top module: `step_div`

## Requirements
- R1: For every cycle in which `op_valid_i` is high, `result_valid_o` is high in the next cycle. After a cycle with `op_valid_i` low, both `result_valid_o` and `err_o` are low.
- R2: A start operation (`op_i`=0) with a nonzero `src2_i` does the following:
  - clears the quotient;
  - takes `src1_i` as the remainder;
  - latches `src2_i` as the divisor;
  - applies one align pass (R4);
  - returns `dest_i` unchanged.
- R3: A start operation with `src2_i`=0 raises `err_o` and leaves quotient, remainder and divisor unchanged. A step operation with a nonzero count while the held divisor is zero also raises `err_o` and changes no state. In both cases the result is `dest_i`.
- R4: An align pass does nothing when the divisor exceeds the remainder. Otherwise it works as follows:
  - shift the divisor left by (top set bit of remainder − top set bit of divisor), and let the quotient bit be 1 shifted by the same amount;
  - if the shifted divisor is now larger than the remainder, halve both the shifted divisor and the quotient bit;
  - add the quotient bit to the quotient and subtract the shifted divisor from the remainder.

  Example: remainder 48, divisor 31 gives quotient 1, remainder 17.
- R5: A step operation (`op_i`=1) whose count (`src2_i` low bits) is zero leaves quotient and remainder unchanged and returns a count of 0.
- R6: A step operation with a nonzero count first repeats the following while the remainder is below the divisor and the count is nonzero:
  - shift bit (count−1) of `src1_i` into the remainder's LSB;
  - shift the quotient left by one;
  - decrement the count.

  It then applies one align pass.
- R7: A step operation returns the updated count, merged into `dest_i` at `size_i`. That count never exceeds the count supplied.
- R8: A step with `flag_en_i` high sets `zero_flag_o` when the returned count is 0 and clears it otherwise. A step with `flag_en_i` low leaves `zero_flag_o` unchanged.
- R9: The read operations return the quotient (`op_i`=2) or the remainder (`op_i`=3), merged into `dest_i`. The merge replaces the low 1, 2, 4 or 8 bytes for `size_i` = 0, 1, 2 or 3 and keeps the rest of `dest_i`.
- R10: Reset clears quotient, remainder, divisor, `zero_flag_o`, `result_o`, `result_valid_o` and `err_o`.
- R11: Suppose a start with upper part H is followed by steps that supply count k and low part L until a step returns 0. Then the quotient and remainder equal (H·2^k + L) / divisor and (H·2^k + L) mod divisor, provided the quotient fits in DATA_W bits and the divisor's top bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation issued this cycle |
| op_i | input | 2 | 0 start, 1 step, 2 read quotient, 3 read remainder |
| size_i | input | 2 | Result lane width: 1, 2, 4 or 8 bytes |
| flag_en_i | input | 1 | Step updates the zero flag |
| src1_i | input | DATA_W | Start: dividend upper part; step: low-dividend register |
| src2_i | input | DATA_W | Start: divisor; step: remaining bit count (low bits) |
| dest_i | input | DATA_W | Prior destination value used as merge base |
| result_valid_o | output | 1 | Result of the previous cycle's operation is present |
| result_o | output | DATA_W | Merged result |
| zero_flag_o | output | 1 | Step-count zero flag |
| err_o | output | 1 | Divide by zero on the previous operation |

## Verification
The properties assume the following about the inputs:
- A step count never exceeds DATA_W.
- A step's count is at most the width of the lane it is merged into.
- The remainder-bound property holds only while the divisor's top bit is clear, because otherwise a remainder shift could overflow.

The stimulus keeps within these limits by using divisors below 64, upper and lower dividend parts of one byte, and a count of 8 merged at byte width. The sweep covers every divisor from 1 to 63 against 32 dividends each. The bench checks the state after the start pass against a largest-fitting-multiple model. It checks the final quotient and remainder against plain integer division. Separate checks cover the zero-divisor, zero-count and flag-hold cases.

// File: rtl/step_div_pkg.sv
package step_div_pkg;
  typedef enum logic [1:0] {
    OP_INIT   = 2'd0,
    OP_STEP   = 2'd1,
    OP_RD_QUO = 2'd2,
    OP_RD_REM = 2'd3
  } div_op_e;
endpackage

// File: rtl/msb_enc.sv
module msb_enc #(
  parameter int W = 64,
  localparam int PW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [PW-1:0] pos_o
);
  always_comb begin
    pos_o = '0;
    for (int i = 0; i < W; i++)
      if (vec_i[i]) pos_o = PW'(i);
  end
endmodule

// File: rtl/div_align.sv
module div_align #(
  parameter int W = 64
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] div_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  localparam int PW = $clog2(W);

  logic [PW-1:0] rem_msb, div_msb, sh;
  logic [W-1:0]  dsh, qbit;
  logic          take;

  msb_enc #(.W(W)) u_rem_msb (.vec_i(rem_i), .pos_o(rem_msb));
  msb_enc #(.W(W)) u_div_msb (.vec_i(div_i), .pos_o(div_msb));

  always_comb begin
    take = (div_i != '0) && (div_i <= rem_i);
    sh   = rem_msb - div_msb;
    dsh  = div_i << sh;
    qbit = W'(1) << sh;
    // overshoot: back off one position
    if (dsh > rem_i) begin
      dsh  = dsh >> 1;
      qbit = qbit >> 1;
    end
    rem_o = take ? rem_i - dsh  : rem_i;
    quo_o = take ? quo_i + qbit : quo_i;
  end
endmodule

// File: rtl/div_pull.sv
module div_pull #(
  parameter int W  = 64,
  parameter int CW = 7
) (
  input  logic [W-1:0]  rem_i,
  input  logic [W-1:0]  quo_i,
  input  logic [W-1:0]  div_i,
  input  logic [W-1:0]  low_i,
  input  logic [CW-1:0] cnt_i,
  output logic [W-1:0]  rem_o,
  output logic [W-1:0]  quo_o,
  output logic [CW-1:0] cnt_o
);
  always_comb begin
    logic [W-1:0]  r, q, sel;
    logic [CW-1:0] c, cm1;
    r = rem_i;
    q = quo_i;
    c = cnt_i;
    for (int k = 0; k < W; k++) begin
      cm1 = c - CW'(1);
      sel = low_i >> cm1;
      if (r < div_i && c != '0) begin
        r = {r[W-2:0], sel[0]};
        q = q << 1;
        c = cm1;
      end
    end
    rem_o = r;
    quo_o = q;
    cnt_o = c;
  end
endmodule

// File: rtl/lane_merge.sv
module lane_merge #(
  parameter int W = 64
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] val_i,
  input  logic [1:0]   size_i,
  output logic [W-1:0] out_o
);
  localparam int NB = W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam int NEED = (b == 0) ? 0 : $clog2(b + 1);
    assign out_o[b*8 +: 8] = (int'(size_i) >= NEED) ? val_i[b*8 +: 8] : base_i[b*8 +: 8];
  end
endmodule

// File: rtl/step_div.sv
module step_div
  import step_div_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [1:0]        op_i,
  input  logic [1:0]        size_i,
  input  logic              flag_en_i,
  input  logic [DATA_W-1:0] src1_i,
  input  logic [DATA_W-1:0] src2_i,
  input  logic [DATA_W-1:0] dest_i,
  output logic              result_valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_flag_o,
  output logic              err_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  div_op_e           op;
  logic [DATA_W-1:0] q_q, r_q, d_q, res_q;
  logic              rv_q, err_q, zf_q;
  logic [CNT_W-1:0]  cnt_in, p_cnt;
  logic [DATA_W-1:0] p_rem, p_quo, s_rem, s_quo, i_rem, i_quo;
  logic [DATA_W-1:0] merge_val, merged;
  logic              step_err, init_err;

  assign op       = div_op_e'(op_i);
  assign cnt_in   = src2_i[CNT_W-1:0];
  assign step_err = (op == OP_STEP) && (cnt_in != '0) && (d_q == '0);
  assign init_err = (op == OP_INIT) && (src2_i == '0);

  div_pull #(.W(DATA_W), .CW(CNT_W)) u_pull (
    .rem_i(r_q), .quo_i(q_q), .div_i(d_q), .low_i(src1_i), .cnt_i(cnt_in),
    .rem_o(p_rem), .quo_o(p_quo), .cnt_o(p_cnt)
  );

  div_align #(.W(DATA_W)) u_step_align (
    .rem_i(p_rem), .quo_i(p_quo), .div_i(d_q),
    .rem_o(s_rem), .quo_o(s_quo)
  );

  div_align #(.W(DATA_W)) u_init_align (
    .rem_i(src1_i), .quo_i('0), .div_i(src2_i),
    .rem_o(i_rem), .quo_o(i_quo)
  );

  always_comb begin
    unique case (op)
      OP_RD_QUO: merge_val = q_q;
      OP_RD_REM: merge_val = r_q;
      OP_STEP:   merge_val = step_err ? dest_i : DATA_W'(p_cnt);
      default:   merge_val = dest_i;
    endcase
  end

  lane_merge #(.W(DATA_W)) u_merge (
    .base_i(dest_i), .val_i(merge_val), .size_i(size_i), .out_o(merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q   <= '0;
      r_q   <= '0;
      d_q   <= '0;
      res_q <= '0;
      rv_q  <= 1'b0;
      err_q <= 1'b0;
      zf_q  <= 1'b0;
    end else if (op_valid_i) begin
      rv_q  <= 1'b1;
      res_q <= merged;
      err_q <= init_err | step_err;
      if (op == OP_INIT && !init_err) begin
        q_q <= i_quo;
        r_q <= i_rem;
        d_q <= src2_i;
      end
      if (op == OP_STEP && !step_err) begin
        if (cnt_in != '0) begin
          q_q <= s_quo;
          r_q <= s_rem;
        end
        if (flag_en_i) zf_q <= (p_cnt == '0);
      end
    end else begin
      rv_q  <= 1'b0;
      err_q <= 1'b0;
    end
  end

  assign result_valid_o = rv_q;
  assign result_o       = res_q;
  assign zero_flag_o    = zf_q;
  assign err_o          = err_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i |=> result_valid_o); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid_i |=> (!result_valid_o && !err_o)); // R1
  AST_ZDIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op == OP_INIT && src2_i == '0)
      |=> (err_o && $stable(q_q) && $stable(r_q) && $stable(d_q))); // R3
  AST_STEP_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op == OP_STEP && cnt_in == '0)
      |=> ($stable(q_q) && $stable(r_q) && result_o[CNT_W-1:0] == '0)); // R5
  AST_CNT_NONINC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op == OP_STEP && !step_err)
      |=> (result_o[CNT_W-1:0] <= $past(src2_i[CNT_W-1:0]))); // R7
  AST_ZF_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op == OP_STEP && flag_en_i && !step_err)
      |=> (zero_flag_o == (result_o[CNT_W-1:0] == '0))); // R8
  AST_READ_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_i[1] && size_i == 2'd0)
      |=> (result_o[DATA_W-1:8] == $past(dest_i[DATA_W-1:8]))); // R9
  AST_REM_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op == OP_STEP && cnt_in != '0 && d_q != '0 && !d_q[DATA_W-1])
      |=> (result_o[CNT_W-1:0] != '0 || r_q < d_q)); // R11
endmodule

// File: tb/step_div_bench.sv
`timescale 1ns/1ps
module step_div_bench;
  localparam logic [63:0] BASE = 64'hA5A5_A5A5_A5A5_A5A5;
  localparam logic [63:0] ONES = '1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op = '0, size = '0;
  logic        flag_en = 1'b0;
  logic [63:0] src1 = '0, src2 = '0, dest = '0;
  logic        rvalid, zflag, err;
  logic [63:0] res;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  step_div u_step_div (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_i(op), .size_i(size),
    .flag_en_i(flag_en), .src1_i(src1), .src2_i(src2), .dest_i(dest),
    .result_valid_o(rvalid), .result_o(res), .zero_flag_o(zflag), .err_o(err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [1:0] o, input logic [1:0] sz, input logic fe,
                       input logic [63:0] a, input logic [63:0] b, input logic [63:0] d);
    @(negedge clk);
    op_valid = 1'b1; op = o; size = sz; flag_en = fe; src1 = a; src2 = b; dest = d;
    @(posedge clk);
    #1;
    op_valid = 1'b0;
  endtask

  task automatic read_qr(output logic [63:0] q, output logic [63:0] r);
    do_op(2'd2, 2'd3, 1'b0, '0, '0, '0);
    q = res;
    do_op(2'd3, 2'd3, 1'b0, '0, '0, '0);
    r = res;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] q, r, eq, er, n;
    logic [7:0]  cnt, newc;
    repeat (3) @(posedge clk);
    #1;
    chk("R10 valid", {63'd0, rvalid}, 64'd0);
    chk("R10 err", {63'd0, err}, 64'd0);
    chk("R10 zflag", {63'd0, zflag}, 64'd0);
    chk("R10 result", res, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    read_qr(q, r);
    chk("R10 quotient", q, 64'd0);
    chk("R10 remainder", r, 64'd0);

    // step with no divisor loaded
    do_op(2'd1, 2'd0, 1'b0, 64'hFF, 64'd3, BASE);
    chk("R3 step zero div err", {63'd0, err}, 64'd1);
    chk("R3 step zero div result", res, BASE);
    chk("R1 valid", {63'd0, rvalid}, 64'd1);
    @(posedge clk); #1;
    chk("R1 idle valid", {63'd0, rvalid}, 64'd0);
    chk("R1 idle err", {63'd0, err}, 64'd0);

    // back-off case
    do_op(2'd0, 2'd3, 1'b0, 64'd48, 64'd31, BASE);
    chk("R2 init result", res, BASE);
    read_qr(q, r);
    chk("R4 backoff quotient", q, 64'd1);
    chk("R4 backoff remainder", r, 64'd17);

    // zero-count, flag-hold and pull example
    do_op(2'd0, 2'd3, 1'b0, 64'd0, 64'd5, BASE);
    do_op(2'd1, 2'd0, 1'b1, 64'hFF, 64'd0, BASE);
    chk("R5 zero count result", res, {BASE[63:8], 8'd0});
    chk("R8 zflag set", {63'd0, zflag}, 64'd1);
    read_qr(q, r);
    chk("R5 quotient unchanged", q, 64'd0);
    chk("R5 remainder unchanged", r, 64'd0);
    do_op(2'd1, 2'd0, 1'b0, 64'hFF, 64'd8, BASE);
    chk("R6 returned count", res, {BASE[63:8], 8'd5});
    chk("R8 flag held", {63'd0, zflag}, 64'd1);
    read_qr(q, r);
    chk("R6 quotient", q, 64'd1);
    chk("R6 remainder", r, 64'd2);
    do_op(2'd1, 2'd0, 1'b1, 64'hFF, 64'd5, BASE);
    chk("R6 second count", res, {BASE[63:8], 8'd4});
    chk("R8 flag cleared", {63'd0, zflag}, 64'd0);
    read_qr(q, r);
    chk("R6 second quotient", q, 64'd3);
    chk("R6 second remainder", r, 64'd0);

    // lane merge widths
    do_op(2'd0, 2'd3, 1'b0, 64'h0123_4567_89AB_CDEF, 64'd1, ONES);
    chk("R2 init dest passthru", res, ONES);
    do_op(2'd3, 2'd0, 1'b0, '0, '0, ONES);
    chk("R9 size byte", res, 64'hFFFF_FFFF_FFFF_FFEF);
    do_op(2'd3, 2'd1, 1'b0, '0, '0, ONES);
    chk("R9 size half", res, 64'hFFFF_FFFF_FFFF_CDEF);
    do_op(2'd3, 2'd2, 1'b0, '0, '0, ONES);
    chk("R9 size word", res, 64'hFFFF_FFFF_89AB_CDEF);
    do_op(2'd3, 2'd3, 1'b0, '0, '0, ONES);
    chk("R9 size full rem", res, 64'h0023_4567_89AB_CDEF);
    do_op(2'd2, 2'd3, 1'b0, '0, '0, ONES);
    chk("R9 size full quo", res, 64'h0100_0000_0000_0000);

    // divide by zero on start
    do_op(2'd0, 2'd3, 1'b0, 64'd5, 64'd0, BASE);
    chk("R3 init zero div err", {63'd0, err}, 64'd1);
    chk("R3 init zero div result", res, BASE);
    read_qr(q, r);
    chk("R3 quotient held", q, 64'h0100_0000_0000_0000);
    chk("R3 remainder held", r, 64'h0023_4567_89AB_CDEF);

    // sweep
    for (int d = 1; d < 64; d++) begin
      for (int j = 0; j < 32; j++) begin
        logic [63:0] hi, lo;
        int guard;
        hi = 64'((j * 37 + d * 5) % 256);
        lo = 64'((j * 91 + d * 13) % 256);
        n  = (hi << 8) | lo;
        do_op(2'd0, 2'd3, 1'b0, hi, 64'(d), BASE);
        if (64'(d) > hi) begin
          eq = 0; er = hi;
        end else begin
          int s;
          s = 0;
          while ((64'(d) << (s + 1)) <= hi) s++;
          eq = 64'd1 << s;
          er = hi - (64'(d) << s);
        end
        read_qr(q, r);
        chk("R2 R4 sweep init quotient", q, eq);
        chk("R2 R4 sweep init remainder", r, er);
        cnt = 8'd8;
        guard = 0;
        while (cnt != 0 && guard < 20) begin
          do_op(2'd1, 2'd0, 1'b1, lo, {56'd0, cnt}, BASE);
          newc = res[7:0];
          chk("R7 count upper lanes", {8'd0, res[63:8]}, {8'd0, BASE[63:8]});
          chk("R7 count not above", {63'd0, newc <= cnt}, 64'd1);
          chk("R8 flag tracks count", {63'd0, zflag}, {63'd0, newc == 0});
          cnt = newc;
          guard++;
        end
        read_qr(q, r);
        chk("R11 quotient", q, n / 64'(d));
        chk("R11 remainder", r, n % 64'(d));
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule